// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is a single 16-bit timer channel with an 8-bit prescale field. It supports one-shot, periodic and pulse-width modulated operation. Software configures it through a write-only register port. The block drives single-cycle timeout and match pulses and a PWM level. It also makes the live count and a prescale snapshot available to the rest of the chip.

The prescale field is used in one of two ways, chosen by the mode:

- **Divider role.** When a one-shot or periodic channel counts down, the prescaler is a true clock divider. It must run down to zero before the 16-bit count moves by one step.
- **Count-extension role.** In up-counting one-shot or periodic operation, and in PWM operation, the prescaler and the low count form a single 24-bit counter. Here the prescaler holds the upper eight bits and takes the carry from the low sixteen.

A snapshot of the prescale setting is also kept. It follows the register either on every cycle or only at each timeout, as software chooses.

Top module: `pscl_timer`

## Requirements
- R1: After synchronous reset, `count_value` is 0, `tmo_pulse`, `match_pulse` and `pwm_out` are 0, `psnap_value` is 0, and every configuration register is 0.
- R2: A write with `wr_en` high stores `wr_data` at the clock edge. The register addresses are:
  - Address 0 is control: bit 0 enable, bits 2:1 mode (0 one-shot, 1 periodic, 2 PWM, 3 periodic), bit 3 count up, bit 4 snapshot-at-timeout.
  - Address 1 is the 16-bit load value.
  - Address 2 is the 16-bit match value.
  - Address 3 is the 8-bit prescale.
  - Address 4 is the 8-bit prescale match.
  - Address 5 is the 24-bit count value.
  - Other addresses are ignored.
- R3: In one-shot or periodic mode with count up = 0 (divider role), the prescaler decrements on each enabled cycle. When it is 0, the next enabled cycle reloads it from the prescale register and decrements the low count. A periodic period lasts (load+1)*(prescale+1) cycles.
- R4: In up-counting one-shot or periodic mode, and in PWM mode (which always counts down), the count is one 24-bit value {prescaler, low}. It steps by one each enabled cycle, with carry or borrow between bit 15 and bit 16.
- R5: `count_value` carries the low count in bits 15:0 and the prescaler in bits 23:16. Bits 31:24 are always 0.
- R6: A timeout occurs when a down count steps from 0, or when an up count steps from {prescale, load}.
  - A down count then reloads to {prescale, load`}`; an up count reloads to 0.
  - `tmo_pulse` is high for that one cycle, in the same cycle that `count_value` first shows the reloaded value.
- R7: In one-shot mode a timeout clears the enable bit, and the count then stays at its reloaded value. In periodic and PWM modes counting continues. A control write in the same cycle as the timeout takes priority over the clear.
- R8: In one-shot and periodic modes, `match_pulse` is high for one cycle when the count steps to the value {prescale match, match}, in the cycle that `count_value` shows it.
- R9: A write to address 5 loads bits 23:0 into the count on the clock edge after the write edge. That edge does not otherwise step the count.
- R10: In PWM mode `pwm_out` is 1 exactly in the cycles where `count_value` is below {prescale match, match}. This gives a duty of match/(load+1) when the prescale is 0. In the other modes `pwm_out` is 0.
- R11: When snapshot-at-timeout is 0, `psnap_value` equals the prescale register one cycle after that register is written. When it is 1, `psnap_value` holds and takes the prescale register only in the timeout cycle.
- R12: While enable is 0 and no count-value write is pending, the count holds and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| tmo_pulse | output | 1 | Single-cycle timeout pulse |
| match_pulse | output | 1 | Single-cycle match pulse |
| pwm_out | output | 1 | PWM level |
| count_value | output | 32 | Live count: prescaler in 23:16, low count in 15:0 |
| psnap_value | output | 8 | Prescale snapshot |

## Verification
Two pairs of functions can fall in the same cycle.

- **Timeout and match.** The two pulses coincide when the match value equals the reload value of a down count. The bench provokes this by rewriting the match value to the load value while a periodic count runs. It then requires `match_pulse` to be high in the very sample where `tmo_pulse` rises, with the count showing the reload value.
- **Count-value write and a normal step.** A count-value write can land in a cycle where the count would otherwise step. The bench writes a new count during a run. It judges that the written value appears exactly one edge later, unmodified, and that counting resumes from it on the following edge.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_PWM      = 2'd2,
    MODE_PER_ALT  = 2'd3
  } tmr_mode_e;

  // control word, bit 0 is the enable
  typedef struct packed {
    logic      snap_on_tmo;
    logic      count_up;
    tmr_mode_e mode;
    logic      enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_LOAD   = 3'd1;
  localparam logic [2:0] ADDR_MATCH  = 3'd2;
  localparam logic [2:0] ADDR_PSCL   = 3'd3;
  localparam logic [2:0] ADDR_PMATCH = 3'd4;
  localparam logic [2:0] ADDR_VALUE  = 3'd5;

endpackage

// File: rtl/pscl_regs.sv
module pscl_regs
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   oneshot_done,
  output ctrl_t                  ctrl,
  output logic [CNT_W-1:0]       load_val,
  output logic [CNT_W-1:0]       match_val,
  output logic [PRE_W-1:0]       pscl_val,
  output logic [PRE_W-1:0]       pmatch_val,
  output logic                   vload_pend,
  output logic [CNT_W+PRE_W-1:0] vload_data
);

  localparam int TOT_W = CNT_W + PRE_W;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:TOT_W];

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      load_val   <= '0;
      match_val  <= '0;
      pscl_val   <= '0;
      pmatch_val <= '0;
      vload_pend <= 1'b0;
      vload_data <= '0;
    end else begin
      vload_pend <= 1'b0;
      // one-shot completion drops the enable unless software rewrites control
      if (oneshot_done && !ctrl_wr) ctrl.enable <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(ADDR_CTRL):   ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
          ADDR_W'(ADDR_LOAD):   load_val   <= wr_data[CNT_W-1:0];
          ADDR_W'(ADDR_MATCH):  match_val  <= wr_data[CNT_W-1:0];
          ADDR_W'(ADDR_PSCL):   pscl_val   <= wr_data[PRE_W-1:0];
          ADDR_W'(ADDR_PMATCH): pmatch_val <= wr_data[PRE_W-1:0];
          ADDR_W'(ADDR_VALUE): begin
            vload_pend <= 1'b1;
            vload_data <= wr_data[TOT_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pscl_core.sv
module pscl_core
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  tmr_mode_e              mode,
  input  logic                   count_up,
  input  logic [PRE_W-1:0]       pscl_val,
  input  logic [CNT_W-1:0]       load_val,
  input  logic                   vload_pend,
  input  logic [CNT_W+PRE_W-1:0] vload_data,
  output logic [CNT_W+PRE_W-1:0] cnt_q,
  output logic [CNT_W+PRE_W-1:0] cnt_nxt,
  output logic                   upd,
  output logic                   tmo_evt
);

  localparam int TOT_W = CNT_W + PRE_W;
  localparam logic [TOT_W-1:0] TOT_ONE = TOT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] LO_ONE  = CNT_W'(1);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] lo_q;
  logic [TOT_W-1:0] top_val;
  logic             is_pwm, up_eff, div_mode;

  assign {pre_q, lo_q} = cnt_q;
  assign top_val  = {pscl_val, load_val};
  assign is_pwm   = (mode == MODE_PWM);
  assign up_eff   = count_up && !is_pwm;
  assign div_mode = !is_pwm && !count_up;

  always_comb begin
    cnt_nxt = cnt_q;
    tmo_evt = 1'b0;
    upd     = 1'b0;
    if (vload_pend) begin
      cnt_nxt = vload_data;
      upd     = 1'b1;
    end else if (en) begin
      upd = 1'b1;
      if (div_mode) begin
        // true divider: prescaler runs to zero before the low count moves
        if (pre_q != '0) begin
          cnt_nxt = {pre_q - PRE_ONE, lo_q};
        end else if (lo_q == '0) begin
          tmo_evt = 1'b1;
          cnt_nxt = top_val;
        end else begin
          cnt_nxt = {pscl_val, lo_q - LO_ONE};
        end
      end else if (up_eff) begin
        if (cnt_q == top_val) begin
          tmo_evt = 1'b1;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt_q + TOT_ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          tmo_evt = 1'b1;
          cnt_nxt = top_val;
        end else begin
          cnt_nxt = cnt_q - TOT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/pscl_events.sv
module pscl_events
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   upd,
  input  logic                   vload_pend,
  input  logic                   tmo_evt,
  input  logic [CNT_W+PRE_W-1:0] cnt_nxt,
  input  logic [CNT_W+PRE_W-1:0] cmp_val,
  input  tmr_mode_e              mode,
  input  logic                   snap_on_tmo,
  input  logic [PRE_W-1:0]       pscl_val,
  output logic                   tmo_q,
  output logic                   match_q,
  output logic                   pwm_q,
  output logic [PRE_W-1:0]       psnap_q
);

  logic is_pwm, hit;
  assign is_pwm = (mode == MODE_PWM);
  assign hit    = (cnt_nxt == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q   <= 1'b0;
      match_q <= 1'b0;
      pwm_q   <= 1'b0;
      psnap_q <= '0;
    end else begin
      tmo_q   <= tmo_evt;
      match_q <= upd && !vload_pend && !is_pwm && hit;
      pwm_q   <= is_pwm && (cnt_nxt < cmp_val);
      if (!snap_on_tmo || tmo_evt) psnap_q <= pscl_val;
    end
  end

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tmo_pulse,
  output logic              match_pulse,
  output logic              pwm_out,
  output logic [DATA_W-1:0] count_value,
  output logic [PRE_W-1:0]  psnap_value
);

  localparam int TOT_W = CNT_W + PRE_W;

  ctrl_t            ctrl_r;
  logic [CNT_W-1:0] load_val, match_val;
  logic [PRE_W-1:0] pscl_val, pmatch_val;
  logic             vload_pend;
  logic [TOT_W-1:0] vload_data;
  logic [TOT_W-1:0] cnt_q, cnt_nxt, cmp_val;
  logic             upd, tmo_evt, oneshot_done;

  assign cmp_val      = {pmatch_val, match_val};
  assign oneshot_done = tmo_evt && (ctrl_r.mode == MODE_ONESHOT);

  pscl_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oneshot_done(oneshot_done), .ctrl(ctrl_r), .load_val(load_val),
    .match_val(match_val), .pscl_val(pscl_val), .pmatch_val(pmatch_val),
    .vload_pend(vload_pend), .vload_data(vload_data)
  );

  pscl_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst(rst), .en(ctrl_r.enable), .mode(ctrl_r.mode),
    .count_up(ctrl_r.count_up), .pscl_val(pscl_val), .load_val(load_val),
    .vload_pend(vload_pend), .vload_data(vload_data), .cnt_q(cnt_q),
    .cnt_nxt(cnt_nxt), .upd(upd), .tmo_evt(tmo_evt)
  );

  pscl_events #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_events (
    .clk(clk), .rst(rst), .upd(upd), .vload_pend(vload_pend), .tmo_evt(tmo_evt),
    .cnt_nxt(cnt_nxt), .cmp_val(cmp_val), .mode(ctrl_r.mode),
    .snap_on_tmo(ctrl_r.snap_on_tmo), .pscl_val(pscl_val),
    .tmo_q(tmo_pulse), .match_q(match_pulse), .pwm_q(pwm_out), .psnap_q(psnap_value)
  );

  assign count_value = DATA_W'(cnt_q);

endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      count_value,
  input logic                   tmo_pulse,
  input logic                   match_pulse,
  input logic                   pwm_out,
  input logic                   ctrl_en,
  input logic [1:0]             ctrl_mode,
  input logic                   ctrl_up,
  input logic                   vpend,
  input logic [PRE_W-1:0]       pscl_val,
  input logic [CNT_W-1:0]       load_val,
  input logic [CNT_W+PRE_W-1:0] cmp_val
);

  localparam int TOT_W = CNT_W + PRE_W;

  logic [TOT_W-1:0] reload_exp;
  logic             ctrl_wr;
  assign reload_exp = (ctrl_up && ctrl_mode != 2'd2) ? '0 : {pscl_val, load_val};
  assign ctrl_wr    = wr_en && (wr_addr == '0);

  // R5
  cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    count_value[DATA_W-1:TOT_W] == '0);

  // R6
  tmo_reload_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> count_value[TOT_W-1:0] == $past(reload_exp));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tmo_pulse && $past(ctrl_mode) == 2'd0 && !$past(ctrl_wr)) |-> !ctrl_en);

  // R8
  match_value_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> count_value[TOT_W-1:0] == $past(cmp_val));

  // R10
  pwm_level_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_out |-> ($past(ctrl_mode) == 2'd2 && count_value[TOT_W-1:0] < $past(cmp_val)));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !vpend) |=> ($stable(count_value) && !tmo_pulse));

endmodule

bind pscl_timer pscl_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .count_value(count_value), .tmo_pulse(tmo_pulse), .match_pulse(match_pulse),
  .pwm_out(pwm_out), .ctrl_en(ctrl_r.enable), .ctrl_mode(ctrl_r.mode),
  .ctrl_up(ctrl_r.count_up), .vpend(vload_pend), .pscl_val(pscl_val),
  .load_val(load_val), .cmp_val(cmp_val)
);

// File: tb/pscl_timer_test.sv
`timescale 1ns/1ps
module pscl_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tmo_pulse, match_pulse, pwm_out;
  logic [31:0] count_value;
  logic [7:0]  psnap_value;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pscl_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmo_pulse(tmo_pulse), .match_pulse(match_pulse), .pwm_out(pwm_out),
    .count_value(count_value), .psnap_value(psnap_value)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // control: [0] enable, [2:1] mode, [3] up, [4] snapshot at timeout
  task automatic cfg(input logic [1:0] mode, input bit up, input bit snap, input bit en);
    wr(3'd0, {27'd0, snap, up, mode, en});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  // advances until a timeout sample; returns the number of samples taken
  task automatic wait_tmo(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tmo_pulse && n < 2000);
  endtask

  task automatic t_reset();
    do_reset();
    check(count_value == 0, "R1 count", count_value, 0);
    check(!tmo_pulse && !match_pulse, "R1 pulses", {tmo_pulse, match_pulse}, 0);
    check(!pwm_out, "R1 pwm", pwm_out, 0);
    check(psnap_value == 0, "R1 snapshot", psnap_value, 0);
  endtask

  task automatic t_divider();
    int n;
    do_reset();
    wr(3'd1, 3); wr(3'd3, 2); wr(3'd5, 32'h020003);
    tick(1);
    check(count_value == 32'h020003, "R9 value load", count_value, 32'h020003);
    cfg(2'd1, 0, 0, 1);
    tick(1);
    check(count_value == 32'h010003, "R3 prescaler steps first", count_value, 32'h010003);
    tick(2);
    check(count_value == 32'h020002, "R3 low steps at zero", count_value, 32'h020002);
    wait_tmo(n);
    check(count_value == 32'h020003, "R6 down reload", count_value, 32'h020003);
    tick(1);
    check(!tmo_pulse, "R6 single cycle pulse", tmo_pulse, 0);
    wait_tmo(n);
    check(n == 11, "R3 R7 periodic period", n + 1, 12);
  endtask

  task automatic t_linear_up();
    do_reset();
    wr(3'd1, 5); wr(3'd3, 1); wr(3'd5, 32'h00FFFE);
    tick(1);
    cfg(2'd1, 1, 0, 1);
    tick(2);
    check(count_value == 32'h010000, "R4 carry into prescaler", count_value, 32'h010000);
    tick(5);
    check(count_value == 32'h010005 && !tmo_pulse, "R4 up count", count_value, 32'h010005);
    tick(1);
    check(tmo_pulse && count_value == 0, "R6 up reload", count_value, 0);
  endtask

  task automatic t_oneshot();
    int n;
    int extra = 0;
    logic [31:0] held;
    do_reset();
    wr(3'd1, 4); wr(3'd5, 4);
    tick(1);
    cfg(2'd0, 0, 0, 1);
    wait_tmo(n);
    check(n == 5 && count_value == 4, "R7 one-shot timeout", {n[15:0], count_value[15:0]}, {16'd5, 16'd4});
    held = count_value;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (tmo_pulse || count_value != held) extra++;
    end
    check(extra == 0, "R7 one-shot stopped", extra, 0);
  endtask

  task automatic t_match();
    int n;
    do_reset();
    wr(3'd1, 9); wr(3'd2, 5); wr(3'd5, 9);
    tick(1);
    cfg(2'd1, 0, 0, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!match_pulse && n < 100);
    check(count_value == 5 && !tmo_pulse, "R8 match at value", count_value, 5);
    check(!pwm_out, "R10 pwm low outside pwm mode", pwm_out, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!match_pulse && n < 100);
    check(n == 10, "R8 match period", n, 10);
    // coincidence: match equal to the reload value
    wr(3'd2, 9);
    wait_tmo(n);
    check(match_pulse && count_value == 9, "R8 R6 match with timeout", {match_pulse, count_value[30:0]}, {1'b1, 31'd9});
  endtask

  task automatic t_pwm();
    int n;
    int hi = 0;
    int bad = 0;
    do_reset();
    wr(3'd1, 9); wr(3'd2, 3); wr(3'd5, 9);
    tick(1);
    cfg(2'd2, 0, 0, 1);
    wait_tmo(n);
    for (int i = 0; i < 10; i++) begin
      if (pwm_out) hi++;
      if (pwm_out != (count_value[23:0] < 24'd3)) bad++;
      @(negedge clk);
    end
    check(hi == 3, "R10 pwm duty", hi, 3);
    check(bad == 0, "R10 pwm level vs count", bad, 0);
  endtask

  task automatic t_snapshot();
    int n;
    do_reset();
    wr(3'd3, 8'h5A);
    tick(1);
    check(psnap_value == 8'h5A, "R11 immediate snapshot", psnap_value, 8'h5A);
    cfg(2'd1, 0, 1, 0);
    wr(3'd3, 8'h03);
    wr(3'd1, 2); wr(3'd5, 2);
    tick(1);
    cfg(2'd1, 0, 1, 1);
    tick(2);
    check(psnap_value == 8'h5A, "R11 snapshot held", psnap_value, 8'h5A);
    wait_tmo(n);
    check(psnap_value == 8'h03, "R11 snapshot at timeout", psnap_value, 8'h03);
  endtask

  task automatic t_vload();
    do_reset();
    wr(3'd1, 100); wr(3'd5, 50);
    tick(1);
    cfg(2'd1, 0, 0, 1);
    tick(3);
    check(count_value == 47, "R3 running", count_value, 47);
    wr(3'd5, 32'hFFAB0007);
    tick(1);
    check(count_value == 32'h00AB0007, "R9 R5 value write lands", count_value, 32'h00AB0007);
    tick(1);
    check(count_value == 32'h00AA0007, "R9 counting resumes", count_value, 32'h00AA0007);
  endtask

  task automatic t_hold();
    int seen = 0;
    do_reset();
    wr(3'd5, 32'h1234);
    cfg(2'd1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tmo_pulse) seen++;
    end
    check(count_value == 32'h1234 && seen == 0, "R12 disabled hold", count_value, 32'h1234);
    wr(3'd7, 32'hFFFF_FFFF);
    tick(1);
    check(count_value == 32'h1234, "R2 unused address ignored", count_value, 32'h1234);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_divider();
    t_linear_up();
    t_oneshot();
    t_match();
    t_pwm();
    t_snapshot();
    t_vload();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule